// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

The block caches recently used page translations so that a 52-bit segment-extended virtual address can become a 32-bit physical address in the same cycle as the lookup. It holds 64 translations as 32 sets of two ways. A page is 4 KB, so the low 12 address bits go straight through. The upper bits are the 40-bit virtual page number. Its low 5 bits pick the set and the remaining 35 bits are the stored tag. Each entry carries a 20-bit physical page number and 4 protection bits.

A lookup that finds no translation raises a miss flag. System software handles the miss, walks its page tables and installs the translation through the fill port. Keeping the buffer consistent with memory is software's job. Software can clear one set or the whole buffer. When address translation is off, the buffer is transparent: the low 32 bits of the incoming address come out unchanged and the lookup counts as a hit. Each set keeps one recency bit that picks the entry to replace.

Top module: `xtlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup with translation enabled reports a miss.
- R2: A lookup with `lk_valid`=1, `xlat_en`=1 and a matching valid entry sets `lk_hit` in the same cycle. `lk_pa` is {stored page number, `lk_va[11:0]`} and `lk_prot` is the stored protection.
- R3: A lookup with translation enabled and no matching entry sets `lk_miss`=1 and `lk_hit`=0, with `lk_pa`=0 and `lk_prot`=0. `lk_hit` and `lk_miss` are never high together.
- R4: The set is selected by virtual page number bits [4:0] (`lk_va[16:12]`). Two translations with different tags can live in the same set at the same time, and sets do not disturb each other.
- R5: A fill into a set whose two entries are both valid replaces the entry that was least recently used. Both a hit and a fill count as a use. A fill into a set with a free entry takes the free entry.
- R6: A fill whose page number is already present overwrites that entry in place. No duplicate is made and the other entry of the set survives.
- R7: `inv_one` clears both entries of set `inv_idx` at the next clock edge and leaves every other set untouched.
- R8: `inv_all` clears every entry at a single clock edge, and any fill in the same cycle is discarded.
- R9: With `xlat_en`=0, a valid lookup gives `lk_hit`=1, `lk_miss`=0, `lk_pa`=`lk_va[31:0]` and `lk_prot`=4'hF, and it does not change replacement state.
- R10: A fill and an `inv_one` to the same set in the same cycle leave that set empty. A fill to another set in that cycle is installed. A fill becomes visible to lookups from the next cycle.
- R11: With `lk_valid`=0, `lk_hit`, `lk_miss`, `lk_pa` and `lk_prot` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | Address translation enabled |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 52 | Virtual address to translate |
| lk_hit | output | 1 | Translation found, or bypass active |
| lk_miss | output | 1 | No translation; software must fill |
| lk_pa | output | 32 | Physical address |
| lk_prot | output | 4 | Protection bits of the hit |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 40 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_prot | input | 4 | Protection bits to install |
| inv_one | input | 1 | Clear both entries of one set |
| inv_idx | input | 5 | Set to clear |
| inv_all | input | 1 | Clear every entry |

## Verification
A corrupted valid bit or tag shows up at the ports in the very cycle a lookup touches that set. It appears as a false hit with a foreign page number, or as a miss where the reference still holds the translation. A wrong recency bit stays hidden until the next fill into a full set. It then shows one cycle later, when the survivor of the eviction misses and the wrong page hits. The bench compares all four outputs against a behavioural model on every cycle. It steers traffic so that each set is refilled while full, right after hits have reordered it.

// File: rtl/xtlb_pkg.sv
// Package: default geometry of the translation buffer and the way-choice rule
// shared by the fill path. Assumes exactly two ways per set.
package xtlb_pkg;
    localparam int unsigned VA_BITS   = 52;
    localparam int unsigned PA_BITS   = 32;
    localparam int unsigned PAGE_BITS = 12;
    localparam int unsigned PROT_BITS = 4;
    localparam int unsigned SET_COUNT = 32;

    // Way to write on a fill: an entry with the same page first, then a free
    // entry (way 0 preferred), otherwise the recency victim.
    function automatic logic pick_way(input logic same0, input logic same1,
                                      input logic full0, input logic full1,
                                      input logic victim);
        if (same0)       return 1'b0;
        else if (same1)  return 1'b1;
        else if (!full0) return 1'b0;
        else if (!full1) return 1'b1;
        else             return victim;
    endfunction
endpackage

// File: rtl/xtlb_way.sv
// One way of the buffer: per-set valid bit, tag, page number and protection.
// It gives a combinational compare for the lookup port and a second compare for
// the fill port. Assumes SETS is a power of two. On clears, set and global
// clears win over a write in the same cycle.
module xtlb_way #(
    parameter int unsigned TAG_W  = 35,
    parameter int unsigned PPN_W  = 20,
    parameter int unsigned PROT_W = 4,
    parameter int unsigned SETS   = 32,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_match,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PROT_W-1:0] lk_prot,
    input  logic [IDX_W-1:0]  fl_idx,
    input  logic [TAG_W-1:0]  fl_tag,
    output logic              fl_match,
    output logic              fl_full,
    input  logic              wr_en,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PROT_W-1:0] wr_prot,
    input  logic              clr_one,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              clr_all
);
    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [PPN_W-1:0]  ppn_q  [SETS];
    logic [PROT_W-1:0] prot_q [SETS];

    // Valid bits: reset/global clear, then write, then set clear (last wins).
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            vld_q <= '0;
        end else begin
            if (wr_en)   vld_q[fl_idx]  <= 1'b1;
            if (clr_one) vld_q[clr_idx] <= 1'b0;
        end
    end

    // Payload storage: written on fill, not reset (guarded by valid).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[fl_idx]  <= fl_tag;
            ppn_q[fl_idx]  <= wr_ppn;
            prot_q[fl_idx] <= wr_prot;
        end
    end

    // Lookup and fill-port compares.
    always_comb begin
        lk_match = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_ppn   = ppn_q[lk_idx];
        lk_prot  = prot_q[lk_idx];
        fl_full  = vld_q[fl_idx];
        fl_match = vld_q[fl_idx] && (tag_q[fl_idx] == fl_tag);
    end
endmodule

// File: rtl/xtlb_lru.sv
// Recency state: one bit per set naming the way to replace next. A use of
// way w points the bit at the other way. When a hit and a fill update the same
// set in one cycle, the fill wins.
module xtlb_lru #(
    parameter int unsigned SETS = 32,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             hit_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic [IDX_W-1:0] q_idx,
    output logic             victim
);
    logic [SETS-1:0] old_q;

    // Update the victim pointer on every hit and fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
        end else begin
            if (hit_en)  old_q[hit_idx]  <= ~hit_way;
            if (fill_en) old_q[fill_idx] <= ~fill_way;
        end
    end

    // Victim of the queried set.
    always_comb victim = old_q[q_idx];
endmodule

// File: rtl/xtlb.sv
// Top: two-way set-associative translation buffer with a single-cycle lookup,
// a fill port driven by miss-handling software, set and global invalidation,
// and a bypass when translation is off. Assumes VA_W > PA_W > OFF_W.
module xtlb
    import xtlb_pkg::*;
#(
    parameter int unsigned VA_W   = VA_BITS,
    parameter int unsigned PA_W   = PA_BITS,
    parameter int unsigned OFF_W  = PAGE_BITS,
    parameter int unsigned PROT_W = PROT_BITS,
    parameter int unsigned SETS   = SET_COUNT,
    localparam int unsigned VPN_W = VA_W - OFF_W,
    localparam int unsigned PPN_W = PA_W - OFF_W,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned TAG_W = VPN_W - IDX_W,
    localparam int unsigned WAYS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_pa,
    output logic [PROT_W-1:0] lk_prot,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              inv_one,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              inv_all
);
    logic [IDX_W-1:0]  lk_idx, fl_idx;
    logic [TAG_W-1:0]  lk_tag, fl_tag;
    logic [WAYS-1:0]   m_lk, m_fl, full_fl, wr_sel;
    logic [PPN_W-1:0]  w_ppn  [WAYS];
    logic [PROT_W-1:0] w_prot [WAYS];
    logic              victim, fill_way, hit_way, any_hit, xl_look;

    // Split the addresses into set index and tag.
    always_comb begin
        lk_idx = lk_va[OFF_W +: IDX_W];
        lk_tag = lk_va[VA_W-1 -: TAG_W];
        fl_idx = fill_vpn[IDX_W-1:0];
        fl_tag = fill_vpn[VPN_W-1 -: TAG_W];
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        // Write strobe for this way.
        always_comb wr_sel[g] = fill_en && (fill_way == g[0]);

        xtlb_way #(
            .TAG_W (TAG_W),
            .PPN_W (PPN_W),
            .PROT_W(PROT_W),
            .SETS  (SETS)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_idx  (lk_idx),
            .lk_tag  (lk_tag),
            .lk_match(m_lk[g]),
            .lk_ppn  (w_ppn[g]),
            .lk_prot (w_prot[g]),
            .fl_idx  (fl_idx),
            .fl_tag  (fl_tag),
            .fl_match(m_fl[g]),
            .fl_full (full_fl[g]),
            .wr_en   (wr_sel[g]),
            .wr_ppn  (fill_ppn),
            .wr_prot (fill_prot),
            .clr_one (inv_one),
            .clr_idx (inv_idx),
            .clr_all (inv_all)
        );
    end

    // Choose the way a fill writes.
    always_comb fill_way = pick_way(m_fl[0], m_fl[1], full_fl[0], full_fl[1], victim);

    // Hit detection for a translated lookup.
    always_comb begin
        xl_look = lk_valid && xlat_en;
        any_hit = |m_lk;
        hit_way = m_lk[1];
    end

    xtlb_lru #(.SETS(SETS)) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_en  (xl_look && any_hit),
        .hit_idx (lk_idx),
        .hit_way (hit_way),
        .fill_en (fill_en),
        .fill_idx(fl_idx),
        .fill_way(fill_way),
        .q_idx   (fl_idx),
        .victim  (victim)
    );

    // Output mux: idle, bypass, hit, miss.
    always_comb begin
        lk_hit  = 1'b0;
        lk_miss = 1'b0;
        lk_pa   = '0;
        lk_prot = '0;
        if (lk_valid && !xlat_en) begin
            lk_hit  = 1'b1;
            lk_pa   = lk_va[PA_W-1:0];
            lk_prot = '1;
        end else if (xl_look && any_hit) begin
            lk_hit  = 1'b1;
            lk_pa   = {w_ppn[hit_way], lk_va[OFF_W-1:0]};
            lk_prot = w_prot[hit_way];
        end else if (xl_look) begin
            lk_miss = 1'b1;
        end
    end
endmodule

// File: rtl/xtlb_chk.sv
// Checker: port-level properties of the translation buffer, bound to xtlb.
// Assumes the index field sits just above the page offset.
module xtlb_chk #(
    parameter int unsigned PA_W  = 32,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xlat_en,
    input logic             lk_valid,
    input logic [IDX_W-1:0] lk_idx,
    input logic [PA_W-1:0]  lk_low,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [PA_W-1:0]  lk_pa,
    input logic             inv_one,
    input logic [IDX_W-1:0] inv_idx,
    input logic             inv_all
);
    assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss && lk_pa == '0));

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[OFF_W-1:0] == lk_low[OFF_W-1:0]));

    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !xlat_en) |-> (lk_hit && lk_pa == lk_low));

    assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_all) && lk_valid && xlat_en) |-> lk_miss);

    assert_flush_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_one) && lk_valid && xlat_en && lk_idx == $past(inv_idx)) |-> lk_miss);
endmodule

bind xtlb xtlb_chk #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .xlat_en (xlat_en),
    .lk_valid(lk_valid),
    .lk_idx  (lk_va[OFF_W +: IDX_W]),
    .lk_low  (lk_va[PA_W-1:0]),
    .lk_hit  (lk_hit),
    .lk_miss (lk_miss),
    .lk_pa   (lk_pa),
    .inv_one (inv_one),
    .inv_idx (inv_idx),
    .inv_all (inv_all)
);

// File: tb/xtlb_test.sv
// Bench: behavioural reference (queue of translations with use stamps),
// compared against all lookup outputs on every clock.
module xtlb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b1;
    logic        lk_valid = 1'b0;
    logic [51:0] lk_va = '0;
    logic        lk_hit, lk_miss;
    logic [31:0] lk_pa;
    logic [3:0]  lk_prot;
    logic        fill_en = 1'b0;
    logic [39:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [3:0]  fill_prot = '0;
    logic        inv_one = 1'b0;
    logic [4:0]  inv_idx = '0;
    logic        inv_all = 1'b0;

    int checks = 0;
    int failures = 0;
    int t_now = 0;
    string req = "R1";

    typedef struct {
        logic [39:0] vpn;
        logic [19:0] ppn;
        logic [3:0]  prot;
        int          stamp;
    } ent_t;
    ent_t mq[$];

    always #5 clk = ~clk;

    xtlb uut (.*);

    function automatic logic [39:0] mk_vpn(input int tag, input int idx);
        logic [34:0] t = 35'(tag);
        logic [4:0]  s = 5'(idx);
        return {t, s};
    endfunction

    function automatic int find(input logic [39:0] v);
        foreach (mq[i]) if (mq[i].vpn == v) return i;
        return -1;
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare the outputs with the model, then advance the model one edge.
    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            logic        e_hit = 1'b0, e_miss = 1'b0;
            logic [31:0] e_pa = '0;
            logic [3:0]  e_prot = '0;
            if (lk_valid && !xlat_en) begin
                e_hit = 1'b1; e_pa = lk_va[31:0]; e_prot = 4'hF;
            end else if (lk_valid) begin
                int k = find(lk_va[51:12]);
                if (k >= 0) begin
                    e_hit = 1'b1; e_pa = {mq[k].ppn, lk_va[11:0]}; e_prot = mq[k].prot;
                end else e_miss = 1'b1;
            end
            check("hit", 64'(lk_hit), 64'(e_hit));
            check("miss", 64'(lk_miss), 64'(e_miss));
            check("pa", 64'(lk_pa), 64'(e_pa));
            check("prot", 64'(lk_prot), 64'(e_prot));
        end
        if (!rst_n) begin
            mq.delete();
        end else begin
            logic has_hit;
            logic [39:0] hvpn = lk_va[51:12];
            t_now++;
            has_hit = lk_valid && xlat_en && (find(hvpn) >= 0);
            if (inv_all) begin
                mq.delete();
            end else begin
                if (fill_en && !(inv_one && inv_idx == fill_vpn[4:0])) begin
                    int k = find(fill_vpn);
                    if (k >= 0) begin
                        mq[k].ppn = fill_ppn; mq[k].prot = fill_prot; mq[k].stamp = 2*t_now+1;
                    end else begin
                        int cnt = 0, old = -1;
                        foreach (mq[i]) if (mq[i].vpn[4:0] == fill_vpn[4:0]) begin
                            cnt++;
                            if (old < 0 || mq[i].stamp < mq[old].stamp) old = i;
                        end
                        if (cnt >= 2) mq.delete(old);
                        mq.push_back('{fill_vpn, fill_ppn, fill_prot, 2*t_now+1});
                    end
                end
                if (has_hit) begin
                    int k = find(hvpn);
                    if (k >= 0 && mq[k].stamp < 2*t_now) mq[k].stamp = 2*t_now;
                end
                if (inv_one)
                    for (int i = mq.size()-1; i >= 0; i--)
                        if (mq[i].vpn[4:0] == inv_idx) mq.delete(i);
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic look(input logic [39:0] v, input logic [11:0] off);
        lk_valid = 1'b1; lk_va = {v, off};
        tick();
    endtask

    task automatic fill(input logic [39:0] v, input logic [19:0] p, input logic [3:0] pr);
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_prot = pr;
        tick();
        fill_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [39:0] va_a, va_b, va_c, va_d, va_e;
        va_a = mk_vpn(100, 3);  va_b = mk_vpn(200, 3);
        va_c = mk_vpn(300, 7);  va_d = mk_vpn(400, 3);
        va_e = mk_vpn(500, 9);
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1: empty after reset
        req = "R1";
        look(va_a, 12'h000); look(va_c, 12'h123); look(mk_vpn(0, 0), 12'h0);
        // R11: idle lookups are quiet
        req = "R11";
        lk_valid = 1'b0; lk_va = {va_a, 12'hFFF}; tick(); tick();
        // R2: single-cycle hit with offset pass-through
        req = "R2";
        fill(va_a, 20'hAAAAA, 4'h5);
        look(va_a, 12'h000); look(va_a, 12'hABC); look(va_a, 12'hFFF);
        // R10: fill not visible in its own cycle
        req = "R10";
        lk_valid = 1'b1; lk_va = {va_c, 12'h010};
        fill_en = 1'b1; fill_vpn = va_c; fill_ppn = 20'hCCCCC; fill_prot = 4'h3;
        tick(); fill_en = 1'b0;
        look(va_c, 12'h010);
        // R4: two tags share set 3, other set independent
        req = "R4";
        fill(va_b, 20'hBBBBB, 4'h6);
        look(va_a, 12'h001); look(va_b, 12'h002); look(va_c, 12'h003);
        look(mk_vpn(100, 4), 12'h0);
        // R5: use A, then a third fill evicts B
        req = "R5";
        look(va_a, 12'h004);
        fill(va_d, 20'hDDDDD, 4'h9);
        look(va_b, 12'h0); look(va_a, 12'h0); look(va_d, 12'h0);
        look(va_a, 12'h0);
        fill(va_b, 20'h12345, 4'h1);
        look(va_d, 12'h0); look(va_a, 12'h0); look(va_b, 12'h0);
        // R6: refill an existing page in place
        req = "R6";
        fill(va_a, 20'h55555, 4'hE);
        look(va_a, 12'h777); look(va_b, 12'h0);
        // R10: same-set fill and clear leave the set empty
        req = "R10";
        inv_one = 1'b1; inv_idx = 5'd9;
        fill(va_e, 20'hEEEEE, 4'h2);
        inv_one = 1'b0;
        look(va_e, 12'h0);
        inv_one = 1'b1; inv_idx = 5'd3;
        fill(va_e, 20'hEEEEE, 4'h2);
        inv_one = 1'b0;
        look(va_e, 12'h0); look(va_a, 12'h0);
        // R7: clearing set 7 spares set 9
        req = "R7";
        look(va_c, 12'h0);
        inv_one = 1'b1; inv_idx = 5'd7; tick(); inv_one = 1'b0;
        look(va_c, 12'h0); look(va_e, 12'h0);
        // R9: bypass, and no recency change while bypassed
        req = "R9";
        fill(va_a, 20'h11111, 4'h4);
        fill(va_b, 20'h22222, 4'h4);
        xlat_en = 1'b0;
        look(va_a, 12'h321); look(mk_vpn(32'hFFFF, 31), 12'hFFF);
        xlat_en = 1'b1;
        fill(va_d, 20'h33333, 4'h4);
        look(va_a, 12'h0); look(va_b, 12'h0); look(va_d, 12'h0);
        // R8: global clear beats a same-cycle fill
        req = "R8";
        inv_all = 1'b1;
        fill(va_c, 20'h44444, 4'h7);
        inv_all = 1'b0;
        look(va_b, 12'h0); look(va_d, 12'h0); look(va_c, 12'h0); look(va_e, 12'h0);
        // R3: mixed traffic over a small page pool
        req = "R3";
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom_range(0, 9));
            lk_valid = (r != 0);
            xlat_en  = (r != 1);
            lk_va    = {mk_vpn(int'($urandom_range(0, 3)), int'($urandom_range(0, 2))),
                        12'($urandom)};
            fill_en  = (r >= 6);
            fill_vpn = mk_vpn(int'($urandom_range(0, 3)), int'($urandom_range(0, 2)));
            fill_ppn = 20'($urandom);
            fill_prot = 4'($urandom);
            inv_one  = (r == 5) && ($urandom_range(0, 3) == 0);
            inv_idx  = 5'($urandom_range(0, 2));
            inv_all  = (r == 4) && ($urandom_range(0, 7) == 0);
            tick();
        end
        lk_valid = 1'b0; fill_en = 1'b0; inv_one = 1'b0; inv_all = 1'b0; xlat_en = 1'b1;
        tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule